// File: doc/BRIEF.md
# Infrared Carrier Modulator for a Serial Line

This block sits between the serial NRZ output of a UART transmitter and the output pin that drives an infrared emitter. When modulation is enabled, every low bit on the line becomes a burst of a square carrier. Every high bit becomes a steady idle level with no carrier. The carrier comes from a reference clock of 4096 to 8192 kHz. A programmable prescaler divides this clock to sixteen times the carrier rate. A 4-bit phase counter then splits each carrier period into sixteen equal phases, which gives carriers of roughly 30 to 60 kHz. For example, with an 8192 kHz clock a divide value of 12 gives about 39 kHz, and 13 gives about 37 kHz.

The duty of the carrier is set in sixteenths of the period, from 1/16 to 8/16. An invert input swaps the idle and active levels. When modulation is disabled, the line passes straight through, XORed with the invert input. The serial line is a continuous level with no transfer handshake, so the block has no valid/ready port and applies no back-pressure. It accepts one line sample per clock and always presents one output level per clock.

The output is registered. A change on `nrz_in` reaches `tx_out` after two rising clock edges. This gives the pin a glitch-free drive, and the delay is the same in both modes.

Top module: `ir_carrier_mod`

## Requirements
- R1: While `rst_n` is low, `tx_out` is 1, whatever the other inputs are.
- R2: With `mod_en`=1 and `nrz_in` held at 1, `tx_out` stays at the idle level without toggling. The idle level is 1 when `inv_pol`=0 and 0 when `inv_pol`=1.
- R3: With `mod_en`=1 and `nrz_in`=0, `tx_out` carries a carrier. The carrier's active level is the complement of the idle level, so it equals `inv_pol`.
- R4: In each carrier period, `tx_out` is at the active level for exactly (`duty_code`+1) of the 16 phases, and these are the first phases of the period. `duty_code`=7 gives 50% and `duty_code`=0 gives 6.25%.
- R5: Each phase lasts `div_val`+1 clock cycles, so one carrier period lasts 16×(`div_val`+1) cycles. After a full period of a low bit, the next period begins again at the active level.
- R6: A 1-to-0 transition of `nrz_in` restarts the carrier from the start of its active phase. This holds whatever phase the carrier was in before the transition.
- R7: With `mod_en`=0, `tx_out` equals `nrz_in` XOR `inv_pol`, delayed by two clock edges.
- R8: A change of `nrz_in` shows at `tx_out` on the second rising edge after it is sampled, not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (4096–8192 kHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| nrz_in | input | 1 | Serial NRZ line from the transmitter |
| mod_en | input | 1 | 1 = modulate low bits, 0 = pass the line through |
| inv_pol | input | 1 | 1 = idle level 0 and active level 1 |
| duty_code | input | 3 | Active phases per period minus one |
| div_val | input | DIV_W | Prescaler divide value minus one |
| tx_out | output | 1 | Drive for the emitter pin |

## Verification
The main function is tried with a low bit under several combinations of duty code, divide value and polarity. The divide values include 0 (a one-cycle phase) and a realistic value of 12. Counting the active cycles in one period separates a duty error from a phase-length error. Locating the first idle cycle shows whether the active phases open the period. Sampling just after a full period catches a counter that fails to wrap. Pass-through vectors with both polarities separate the bypass path from the modulator. A low bit cut short by a brief high bit shows that the falling edge restarts the carrier and that it does not resume from its old phase.

// File: rtl/irm_pkg.sv
package irm_pkg;
  localparam int PHASE_W = 4;
  localparam int DUTY_W  = 3;
  localparam int PHASES  = 1 << PHASE_W;

  function automatic logic in_burst_window(input logic [PHASE_W-1:0] ph,
                                           input logic [DUTY_W-1:0]  duty);
    return ph <= {1'b0, duty};
  endfunction
endpackage

// File: rtl/irm_line_edge.sv
module irm_line_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_q,
  output logic fall
);
  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_in;
  end

  assign fall = line_q & ~line_in;

  // R6
  fall_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !line_q);
endmodule

// File: rtl/irm_carrier_timer.sv
module irm_carrier_timer
  import irm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [DIV_W-1:0]   div_val,
  output logic [PHASE_W-1:0] phase
);
  logic [DIV_W-1:0] pre_cnt;
  logic             tick;

  assign tick = (pre_cnt >= div_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      phase   <= '0;
    end else if (restart) begin
      pre_cnt <= '0;
      phase   <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      phase   <= phase + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(phase));

  // R5
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && tick) |=> phase == PHASE_W'($past(phase) + 1'b1));

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == '0 && pre_cnt == '0));
endmodule

// File: rtl/irm_shaper.sv
module irm_shaper
  import irm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               inv,
  input  logic [DUTY_W-1:0]  duty,
  input  logic               line_q,
  input  logic [PHASE_W-1:0] phase,
  output logic               tx_out
);
  logic idle_lvl;
  logic burst;
  logic nxt;

  assign idle_lvl = ~inv;
  assign burst    = ~line_q & in_burst_window(phase, duty);

  always_comb begin
    if (en) nxt = burst ? inv : idle_lvl;
    else    nxt = line_q ^ inv;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tx_out <= 1'b1;
    else        tx_out <= nxt;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && line_q) |=> tx_out == !$past(inv));

  // R4
  duty_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !line_q && (phase > {1'b0, duty})) |=> tx_out == !$past(inv));
endmodule

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod
  import irm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nrz_in,
  input  logic             mod_en,
  input  logic             inv_pol,
  input  logic [2:0]       duty_code,
  input  logic [DIV_W-1:0] div_val,
  output logic             tx_out
);
  logic               line_q;
  logic               line_fall;
  logic [PHASE_W-1:0] phase;

  irm_line_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (nrz_in),
    .line_q  (line_q),
    .fall    (line_fall)
  );

  irm_carrier_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (line_fall),
    .div_val (div_val),
    .phase   (phase)
  );

  irm_shaper u_shape (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (mod_en),
    .inv    (inv_pol),
    .duty   (duty_code),
    .line_q (line_q),
    .phase  (phase),
    .tx_out (tx_out)
  );

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)            age <= 2'd0;
    else if (age != 2'd2)  age <= age + 2'd1;
  end

  // R7
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && $past(!mod_en)) |-> tx_out == ($past(nrz_in, 2) ^ $past(inv_pol)));
endmodule

// File: tb/sim_ir_carrier_mod.sv
module sim_ir_carrier_mod;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  // {en[12], inv[11], duty[10:8], div[7:0]}
  localparam logic [12:0] CFG [NV] = '{
    {1'b1, 1'b0, 3'd7, 8'd3},
    {1'b1, 1'b0, 3'd0, 8'd3},
    {1'b1, 1'b1, 3'd3, 8'd2},
    {1'b1, 1'b0, 3'd5, 8'd0},
    {1'b1, 1'b1, 3'd7, 8'd5},
    {1'b0, 1'b0, 3'd2, 8'd3},
    {1'b0, 1'b1, 3'd2, 8'd3},
    {1'b1, 1'b0, 3'd6, 8'd12}
  };
  // active cycles in one period of a low bit
  localparam int EXP_ACT [NV] = '{32, 4, 12, 6, 48, 64, 64, 91};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nrz_in = 1'b1;
  logic       mod_en = 1'b0;
  logic       inv_pol = 1'b0;
  logic [2:0] duty_code = 3'd7;
  logic [7:0] div_val = 8'd3;
  logic       tx_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_carrier_mod #(.DIV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .nrz_in(nrz_in), .mod_en(mod_en),
    .inv_pol(inv_pol), .duty_code(duty_code), .div_val(div_val),
    .tx_out(tx_out)
  );

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset value, with invert set to show it does not matter
    inv_pol = 1'b1;
    mod_en  = 1'b1;
    repeat (3) @(negedge clk);
    chk_bit("R1 reset level", tx_out, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic en, inv, act_lvl, idle_lvl;
      int dv, per, cnt, first_idle;
      en  = CFG[v][12];
      inv = CFG[v][11];
      dv  = int'(CFG[v][7:0]);
      per = 16 * (dv + 1);
      act_lvl  = inv;
      idle_lvl = ~inv;
      mod_en = en; inv_pol = inv; duty_code = CFG[v][10:8]; div_val = CFG[v][7:0];
      nrz_in = 1'b1;
      // R2 / R7: high bit gives the idle level, steady
      cnt = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (i >= 3 && tx_out !== idle_lvl) cnt++;
      end
      chk_int($sformatf("R2 R7 vec%0d idle samples off", v), cnt, 0);
      nrz_in = 1'b0;
      @(negedge clk);
      // R8: one edge after sampling, output still old
      chk_bit($sformatf("R8 vec%0d latency", v), tx_out, idle_lvl);
      @(negedge clk);
      // R3: carrier opens at active level
      chk_bit($sformatf("R3 vec%0d burst start", v), tx_out, act_lvl);
      cnt = 0;
      first_idle = per;
      for (int i = 0; i < per; i++) begin
        if (i > 0) @(negedge clk);
        if (tx_out === act_lvl) cnt++;
        else if (first_idle == per) first_idle = i;
      end
      // R4: number of active cycles = (duty+1)*(div+1)
      chk_int($sformatf("R4 vec%0d active count", v), cnt, EXP_ACT[v]);
      // R4 / R5: active part is contiguous and opens the period
      chk_int($sformatf("R5 vec%0d first idle", v), first_idle,
              en ? EXP_ACT[v] : per);
      @(negedge clk);
      // R5: period is 16*(div+1) cycles, next one starts active
      chk_bit($sformatf("R5 vec%0d wrap", v), tx_out, act_lvl);
      nrz_in = 1'b1;
      repeat (3) @(negedge clk);
    end

    // R6: short high bit in the middle of a burst restarts the carrier
    mod_en = 1'b1; inv_pol = 1'b0; duty_code = 3'd7; div_val = 8'd3;
    nrz_in = 1'b1;
    repeat (10) @(negedge clk);
    nrz_in = 1'b0;
    repeat (10) @(negedge clk);
    nrz_in = 1'b1;
    repeat (3) @(negedge clk);
    nrz_in = 1'b0;
    repeat (2) @(negedge clk);
    begin
      int run;
      run = 0;
      while (tx_out === 1'b0 && run < 100) begin
        run++;
        @(negedge clk);
      end
      chk_int("R6 restart active run", run, 32);
    end

    // R7: pass-through follows a toggling line
    mod_en = 1'b0; inv_pol = 1'b1;
    for (int i = 0; i < 6; i++) begin
      nrz_in = i[0];
      repeat (2) @(negedge clk);
      chk_bit("R7 pass toggle", tx_out, i[0] ^ 1'b1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule